// File: doc/BRIEF.md
# Word-Wide CRC-32 Calculation Peripheral

This block is a memory-mapped CRC-32 accelerator. A bus master writes 32-bit words into the data register. Each accepted write folds the whole word into a running checksum in a single clock cycle. The checksum uses the generator 0x04C11DB7 and shifts left, most significant bit first, with no input or output reflection. Reading the data register returns the running value. Software forms each word from memory bytes in little-endian order, so the first byte sits in bits 7:0. The results then match a plain MSB-first software CRC-32 taken over those words.

The block has four registers, selected by the byte offset on the bus:

| Offset | Register | Behaviour |
|---|---|---|
| 0x00 | data | Write folds a word into the checksum; read returns the checksum. |
| 0x04 | scratch | 8-bit storage that has no effect on the checksum. |
| 0x08 | control | Writing 1 to bit 0 reloads the checksum from the seed register. |
| 0x10 | seed | Programmable initial value, 0xFFFFFFFF after reset. |

Offset 0x0C is an unused gap. A zero residue confirms a signature: run the CRC over a payload, then write the result as one more word, and the checksum becomes 0.

An access-gate state machine follows the clock-enable input. It has two states:
- `ST_GATED`: the block takes no accesses.
- `ST_OPEN`: the block accepts reads and writes.

The transitions are:
- `T_WAKE` (GATED→OPEN) is taken on any cycle with `clk_en` high.
- `T_SLEEP` (OPEN→GATED) is taken on any cycle with `clk_en` low.

An access is accepted only in `ST_OPEN` with `clk_en` high. So the first cycle after the enable rises is still ignored.

Top module: `crc32_unit`

## Requirements
- R1: After reset, a read returns 0xFFFFFFFF at offset 0x00, 0 at offset 0x04, 0 at offset 0x08 and 0xFFFFFFFF at offset 0x10.
- R2: Each accepted write to offset 0x00 replaces the checksum C with the result of 32 left-shift steps, taken from data bit 31 down to bit 0. Each step computes f = C[31] xor d[i] and C = (C << 1) xor (f ? 0x04C11DB7 : 0). The new value is visible to any read issued from the next cycle on.
- R3: Starting from 0xFFFFFFFF, writing the single word 0x0000000A leaves 0xE88E0BAD.
- R4: After any word sequence, writing the resulting checksum as one more word leaves 0x00000000.
- R5: An accepted write to offset 0x08 with bit 0 set loads the checksum from the seed register. Offset 0x08 always reads as 0.
- R6: Offset 0x10 is a read/write 32-bit seed. Writing it does not change the checksum until the next reload.
- R7: Offset 0x04 stores bits 7:0 of the write data and reads back with bits 31:8 zero. It keeps its value across checksum reloads, and writing it leaves the checksum unchanged.
- R8: With `clk_en` low, and in the first cycle after it rises, writes have no effect and reads return 0.
- R9: Offset 0x0C and every other unmapped offset read as 0, and writes to them change no register.
- R10: Read data is registered. It shows the addressed value one cycle after the read strobe, and it is 0 one cycle after a cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Gated clock enable; low blocks all accesses |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
A data write is folded at the edge that samples it. A read strobe presented in the following cycle returns the new checksum on `bus_rdata` just after its own sampling edge, so every result is due one cycle after the read strobe. The bench drives each strobe for exactly one cycle from the falling edge and samples one time unit after the next rising edge. After raising `clk_en`, it idles one cycle before the next access, apart from the one probe that targets the ignored wake cycle on purpose.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [0:0] {
        ST_GATED = 1'b0,
        ST_OPEN  = 1'b1
    } gate_state_t;

    typedef enum logic [2:0] {
        SLOT_DATA    = 3'd0,
        SLOT_SCRATCH = 3'd1,
        SLOT_CTRL    = 3'd2,
        SLOT_GAP     = 3'd3,
        SLOT_SEED    = 3'd4
    } reg_slot_t;

endpackage

// File: rtl/crc32_fold.sv
module crc32_fold #(
    parameter int unsigned        W    = 32,
    parameter logic [W-1:0]       POLY = 32'h04C11DB7
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] crc_out
);
    // stage[k] is the remainder after k bits have been shifted in
    logic [W-1:0] stage [W+1];

    assign stage[0] = crc_in;

    for (genvar k = 0; k < W; k++) begin : g_step
        logic fb;
        assign fb         = stage[k][W-1] ^ word_in[W-1-k];
        assign stage[k+1] = {stage[k][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[W];

endmodule

// File: rtl/crc32_regs.sv
module crc32_regs
    import crc32_pkg::*;
#(
    parameter int unsigned  W       = 32,
    parameter int unsigned  ADDR_W  = 5,
    parameter int unsigned  SCR_W   = 8,
    parameter logic [W-1:0] SEED_RV = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_rd,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      crc_next,
    output logic [W-1:0]      crc_value,
    output logic [W-1:0]      seed_value,
    output logic              gate_open
);
    localparam int unsigned SLOT_W = ADDR_W - 2;

    gate_state_t state_q, state_d;
    logic [SCR_W-1:0] scratch_q;
    logic [SLOT_W-1:0] slot;
    logic acc_wr, acc_rd;
    logic [W-1:0] rd_mux;

    assign slot = bus_addr[ADDR_W-1:2];

    // next-state logic: T_WAKE / T_SLEEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATED: if (clk_en)  state_d = ST_OPEN;
            ST_OPEN:  if (!clk_en) state_d = ST_GATED;
            default:               state_d = ST_GATED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GATED;
        else        state_q <= state_d;
    end

    // outputs: access qualification and read multiplexer
    always_comb begin
        gate_open = 1'b0;
        unique case (state_q)
            ST_GATED: gate_open = 1'b0;
            ST_OPEN:  gate_open = clk_en;
            default:  gate_open = 1'b0;
        endcase
        acc_wr = gate_open && bus_wr;
        acc_rd = gate_open && bus_rd;
        rd_mux = '0;
        if (slot == SLOT_W'(SLOT_DATA))         rd_mux = crc_value;
        else if (slot == SLOT_W'(SLOT_SCRATCH)) rd_mux = W'(scratch_q);
        else if (slot == SLOT_W'(SLOT_SEED))    rd_mux = seed_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_value  <= SEED_RV;
            seed_value <= SEED_RV;
            scratch_q  <= '0;
        end else if (acc_wr) begin
            if (slot == SLOT_W'(SLOT_DATA))
                crc_value <= crc_next;
            else if (slot == SLOT_W'(SLOT_SCRATCH))
                scratch_q <= bus_wdata[SCR_W-1:0];
            else if (slot == SLOT_W'(SLOT_CTRL) && bus_wdata[0])
                crc_value <= seed_value;
            else if (slot == SLOT_W'(SLOT_SEED))
                seed_value <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (acc_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/crc32_unit.sv
module crc32_unit #(
    parameter int unsigned  W       = 32,
    parameter int unsigned  ADDR_W  = 5,
    parameter int unsigned  SCR_W   = 8,
    parameter logic [W-1:0] POLY    = 32'h04C11DB7,
    parameter logic [W-1:0] SEED_RV = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_rd,
    output logic [W-1:0]      bus_rdata
);
    logic [W-1:0] crc_value, crc_next, seed_value;
    logic         gate_open;

    crc32_fold #(.W(W), .POLY(POLY)) u_fold (
        .crc_in  (crc_value),
        .word_in (bus_wdata),
        .crc_out (crc_next)
    );

    crc32_regs #(.W(W), .ADDR_W(ADDR_W), .SCR_W(SCR_W), .SEED_RV(SEED_RV)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .crc_next   (crc_next),
        .crc_value  (crc_value),
        .seed_value (seed_value),
        .gate_open  (gate_open)
    );

endmodule

// File: rtl/crc32_unit_chk.sv
module crc32_unit_chk #(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic              bus_rd,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      crc_value,
    input logic [W-1:0]      seed_value
);
    logic wr_ok, rd_ok;
    logic [ADDR_W-3:0] slot;
    // qualification rebuilt here from ports: enable high now and last cycle
    logic en_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= clk_en;
    end
    assign wr_ok = en_prev && clk_en && bus_wr;
    assign rd_ok = en_prev && clk_en && bus_rd;
    assign slot  = bus_addr[ADDR_W-1:2];

    // R5
    reload_loads_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && slot == 3'd2 && bus_wdata[0]) |=> crc_value == $past(seed_value));

    // R7
    scratch_keeps_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && slot == 3'd1) |=> $stable(crc_value));

    // R6
    seed_write_keeps_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && slot == 3'd4) |=> ($stable(crc_value) && seed_value == $past(bus_wdata)));

    // R8
    gated_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(en_prev && clk_en)) |=> ($stable(crc_value) && $stable(seed_value)));

    // R8
    gated_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(en_prev && clk_en)) |=> bus_rdata == '0);

    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ok) |=> bus_rdata == '0);

    // R9
    gap_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && (slot == 3'd3 || slot > 3'd4)) |=> bus_rdata == '0);

    // R2
    data_write_changes_only_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && slot == 3'd0) |=> $stable(seed_value));
endmodule

bind crc32_unit crc32_unit_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .crc_value  (crc_value),
    .seed_value (seed_value)
);

// File: tb/crc32_unit_test.sv
`timescale 1ns/1ps
module crc32_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    crc32_unit uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            logic f = r[31] ^ d[i];
            r = {r[30:0], 1'b0} ^ (f ? 32'h04C11DB7 : 32'h0);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, model, seed;
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk) clk_en = 1'b1;
        @(negedge clk);

        // R1 reset contents
        rd(5'h00, v); check("R1 data", v, 32'hFFFFFFFF);
        rd(5'h04, v); check("R1 scratch", v, 32'h0);
        rd(5'h08, v); check("R1 ctrl", v, 32'h0);
        rd(5'h10, v); check("R1 seed", v, 32'hFFFFFFFF);

        // R10 idle cycle after a read returns zero
        @(negedge clk); @(posedge clk); #1;
        check("R10 idle", bus_rdata, 32'h0);

        // R3 known vector
        wr(5'h00, 32'h0000000A);
        rd(5'h00, v); check("R3 vector", v, 32'hE88E0BAD);
        // R4 appended signature
        wr(5'h00, v);
        rd(5'h00, v); check("R4 residue fixed", v, 32'h0);

        // R5 reload and control readback
        wr(5'h08, 32'h1);
        rd(5'h08, v); check("R5 ctrl reads 0", v, 32'h0);
        rd(5'h00, v); check("R5 reload", v, 32'hFFFFFFFF);

        // R2 and R4 random sequences
        for (int s = 0; s < 12; s++) begin
            int n = 1 + ($urandom % 20);
            wr(5'h08, 32'h1);
            model = 32'hFFFFFFFF;
            for (int k = 0; k < n; k++) begin
                logic [31:0] w = $urandom;
                if (k == 0 && s == 0) w = 32'h0;
                if (k == 0 && s == 1) w = 32'hFFFFFFFF;
                wr(5'h00, w);
                model = ref_fold(model, w);
            end
            rd(5'h00, v); check("R2 random fold", v, model);
            wr(5'h00, v);
            rd(5'h00, v); check("R4 residue random", v, 32'h0);
        end

        // R6 programmable seed
        seed = 32'h12345678;
        wr(5'h00, 32'hCAFEF00D);
        model = ref_fold(32'hFFFFFFFF, 32'hCAFEF00D);
        wr(5'h08, 32'h1);
        model = 32'hFFFFFFFF;
        wr(5'h10, seed);
        rd(5'h00, v); check("R6 seed write keeps crc", v, model);
        rd(5'h10, v); check("R6 seed readback", v, seed);
        wr(5'h08, 32'h1);
        rd(5'h00, v); check("R6 reload from seed", v, seed);
        wr(5'h00, 32'h00000001);
        rd(5'h00, v); check("R6 fold from seed", v, ref_fold(seed, 32'h1));
        model = v;

        // R7 scratch register
        wr(5'h04, 32'hFFFF01A5);
        rd(5'h04, v); check("R7 scratch width", v, 32'h000000A5);
        rd(5'h00, v); check("R7 crc untouched", v, model);
        wr(5'h08, 32'h1);
        rd(5'h04, v); check("R7 survives reload", v, 32'h000000A5);
        rd(5'h00, v); check("R7 reload after scratch", v, seed);
        model = seed;

        // R9 gap offset
        wr(5'h0C, 32'hDEADBEEF);
        rd(5'h0C, v); check("R9 gap reads 0", v, 32'h0);
        rd(5'h00, v); check("R9 gap write no effect crc", v, model);
        rd(5'h10, v); check("R9 gap write no effect seed", v, seed);
        rd(5'h18, v); check("R9 unmapped reads 0", v, 32'h0);

        // R8 enable low
        @(negedge clk) clk_en = 1'b0;
        wr(5'h00, 32'h11111111);
        wr(5'h10, 32'h22222222);
        rd(5'h00, v); check("R8 gated read", v, 32'h0);
        // wake cycle: write issued in the first enabled cycle is ignored
        @(negedge clk);
        clk_en = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h33333333; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
        rd(5'h00, v); check("R8 writes ignored", v, model);
        rd(5'h10, v); check("R8 seed kept", v, seed);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule